// File: doc/BRIEF.md
# Processor Mode Control Register Bank

This block holds the system control state that selects the operating mode of a processor core: a mode word, a fault-address register, a translation-table base register, a feature word and an extended-feature word. Privileged software reaches them through a single write port and a combinational read port. Both ports are addressed by a 3-bit register index. The page-walk logic reports page faults on a separate capture input, and that input loads the fault-address register directly.

The bank decodes the mode state that the rest of the core consumes. It reports whether the core is in protected mode, whether paging is on and whether long mode is active. It also presents the top-level table base together with its caching attributes. The long-mode-active status is never written by software. It is computed from the long-mode enable and the paging bit. The long-mode enable may change only while paging is off. A write that breaks this ordering rule is dropped, and so is a write to an unimplemented index. Each dropped write raises a one-cycle general-protection strobe.

Top module: `sysctl_regbank`

## Requirements
- R1: During and right after reset, the mode word (index 0) reads 0x10 and every other index reads 0. All mode outputs and the fault strobe are low.
- R2: For the mode word (index 0), bit 0 drives `prot_mode_o` and bit 31 drives `paging_on_o`. Bits 31:0 are writable except bit 4, which always reads 1. Bits 63:32 always read 0.
- R3: For the feature word (index 4), bits 10:0 and bit 18 are writable. All other bits read 0.
- R4: For the extended-feature word (index 5), bits 0, 8, 11, 12, 13 and 14 are writable. Bit 10 is read-only, and all other bits read 0.
- R5: Read bit 10 of index 5 and `long_active_o` are both 1 exactly when extended bit 8 and mode bit 31 are both 1.
- R6: A write to index 5 that changes bit 8 while `paging_on_o` is 1 leaves index 5 unchanged. It drives `gp_fault_o` high for the single cycle after the write edge.
- R7: A write to index 1, 6 or 7 changes no register and pulses `gp_fault_o` in the same way as R6. These indices always read 0.
- R8: When `pf_valid` is high, the fault-address register (index 2) loads `pf_addr` at the edge. A software write to index 2 in the same cycle loses. Without `pf_valid`, a software write to index 2 loads all 64 bits.
- R9: For the table base (index 3), bits 51:3 are writable. Bits 2:0 and 63:52 read 0. Bit 3 drives `tbase_wthru_o` and bit 4 drives `tbase_nocache_o`.
- R10: With feature bit 5 clear, `tbase_addr_o` is index-3 bits 51:12 followed by 12 zero bits. With feature bit 5 set, it is bits 31:5 followed by 5 zero bits, and the upper bits are zero.
- R11: `rd_data` follows `rd_idx` within the same cycle. A write becomes visible on reads and outputs right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | XLEN (64) | Write value |
| rd_idx | input | 3 | Register index of the read |
| rd_data | output | XLEN (64) | Read value, combinational |
| pf_valid | input | 1 | Page fault report |
| pf_addr | input | XLEN (64) | Faulting virtual address |
| prot_mode_o | output | 1 | Protected mode selected |
| paging_on_o | output | 1 | Paging enabled |
| long_active_o | output | 1 | Long mode active |
| tbase_addr_o | output | PA_W (52) | Decoded top-level table base |
| tbase_wthru_o | output | 1 | Top-level table writethrough |
| tbase_nocache_o | output | 1 | Top-level table uncacheable |
| gp_fault_o | output | 1 | One-cycle general-protection strobe |

## Verification
The bench builds the bank with XLEN = 64 and PA_W = 52. With XLEN = 64, the reserved upper halves of the mode and table-base words exist, so writes of all ones can show that those bits stay zero. With PA_W = 52, the table base has real bits above bit 31, so the two base decodings give visibly different results for the same stored value. At these widths the bench also reaches the long-mode ordering rule, back-to-back faults and the collision between a page fault and a software write.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

   typedef enum logic [2:0] {
      SEL_MODE  = 3'd0,
      SEL_HOLE1 = 3'd1,
      SEL_FADDR = 3'd2,
      SEL_TBASE = 3'd3,
      SEL_FEAT  = 3'd4,
      SEL_EXT   = 3'd5,
      SEL_HOLE6 = 3'd6,
      SEL_HOLE7 = 3'd7
   } reg_sel_e;

   // bit positions that neighbouring logic decodes
   localparam int MODE_PROT_B    = 0;
   localparam int MODE_PAGE_B    = 31;
   localparam int MODE_FIXED_B   = 4;
   localparam int FEAT_WIDE_B    = 5;
   localparam int EXT_LONGEN_B   = 8;
   localparam int EXT_LONGACT_B  = 10;
   localparam int TB_WTHRU_B     = 3;
   localparam int TB_NOCACHE_B   = 4;
   localparam int DIR_ALIGN      = 12;
   localparam int PTR_ALIGN      = 5;
   localparam int PTR_TOP        = 31;

   // slots of the masked register array
   localparam int SLOT_MODE  = 0;
   localparam int SLOT_TBASE = 1;
   localparam int SLOT_FEAT  = 2;
   localparam int SLOT_EXT   = 3;
   localparam int N_SLOTS    = 4;

   typedef struct packed {
      logic mode;
      logic faddr;
      logic tbase;
      logic feat;
      logic ext;
      logic illegal;
   } commit_t;

endpackage

// File: rtl/sysctl_guard.sv
`timescale 1ns/1ps
module sysctl_guard
   import sysctl_pkg::*;
(
   input  logic       wr_en,
   input  logic [2:0] wr_idx,
   input  logic       new_longen,
   input  logic       cur_longen,
   input  logic       paging_on,
   output commit_t    commit
);

   always_comb begin
      commit = '0;
      if (wr_en) begin
         unique case (reg_sel_e'(wr_idx))
            SEL_MODE:  commit.mode  = 1'b1;
            SEL_FADDR: commit.faddr = 1'b1;
            SEL_TBASE: commit.tbase = 1'b1;
            SEL_FEAT:  commit.feat  = 1'b1;
            SEL_EXT: begin
               if (paging_on && (new_longen != cur_longen))
                  commit.illegal = 1'b1;
               else
                  commit.ext = 1'b1;
            end
            default:   commit.illegal = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/sysctl_field_reg.sv
`timescale 1ns/1ps
module sysctl_field_reg #(
   parameter int             W     = 64,
   parameter logic [W-1:0]   WMASK = '0,
   parameter logic [W-1:0]   FIXED = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_q <= '0;
      else if (we)
         held_q <= d & WMASK;
   end

   assign q = (held_q & WMASK) | FIXED;

endmodule

// File: rtl/sysctl_fault_cap.sv
`timescale 1ns/1ps
module sysctl_fault_cap #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pf_valid,
   input  logic [W-1:0] pf_addr,
   input  logic         sw_we,
   input  logic [W-1:0] sw_data,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (pf_valid)
         q <= pf_addr;
      else if (sw_we)
         q <= sw_data;
   end

endmodule

// File: rtl/sysctl_base_dec.sv
`timescale 1ns/1ps
module sysctl_base_dec
   import sysctl_pkg::*;
#(
   parameter int PA_W = 52
) (
   input  logic [PA_W-1:3] word,
   input  logic            wide_mode,
   output logic [PA_W-1:0] base_addr,
   output logic            wthru,
   output logic            nocache
);

   logic [PA_W-1:0] dir_base;
   logic [PA_W-1:0] ptr_base;

   assign dir_base = {word[PA_W-1:DIR_ALIGN], {DIR_ALIGN{1'b0}}};

   generate
      if (PA_W == PTR_TOP + 1) begin : g_ptr_flush
         assign ptr_base = {word[PTR_TOP:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
      end else begin : g_ptr_pad
         assign ptr_base = {{(PA_W-PTR_TOP-1){1'b0}},
                            word[PTR_TOP:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
      end
   endgenerate

   assign base_addr = wide_mode ? ptr_base : dir_base;
   assign wthru     = word[TB_WTHRU_B];
   assign nocache   = word[TB_NOCACHE_B];

endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int PA_W = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_idx,
   input  logic [XLEN-1:0] wr_data,
   input  logic [2:0]      rd_idx,
   output logic [XLEN-1:0] rd_data,
   input  logic            pf_valid,
   input  logic [XLEN-1:0] pf_addr,
   output logic            prot_mode_o,
   output logic            paging_on_o,
   output logic            long_active_o,
   output logic [PA_W-1:0] tbase_addr_o,
   output logic            tbase_wthru_o,
   output logic            tbase_nocache_o,
   output logic            gp_fault_o
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("sysctl_regbank: XLEN must be 32 or 64");
      end
      if (PA_W < PTR_TOP + 1 || PA_W > XLEN) begin : g_bad_paw
         $error("sysctl_regbank: PA_W must lie in 32..XLEN");
      end
   endgenerate

   localparam logic [XLEN-1:0] MODE_WMASK = XLEN'(64'h0000_0000_FFFF_FFEF);
   localparam logic [XLEN-1:0] MODE_FIXED = XLEN'(64'h1) << MODE_FIXED_B;
   localparam logic [XLEN-1:0] FEAT_WMASK = XLEN'(64'h0000_0000_0004_07FF);
   localparam logic [XLEN-1:0] EXT_WMASK  = XLEN'(64'h0000_0000_0000_7901);
   localparam logic [XLEN-1:0] TB_WMASK   =
      XLEN'(((65'd1 << PA_W) - 65'd1) & ~65'd7);

   localparam logic [N_SLOTS-1:0][XLEN-1:0] SLOT_WMASK =
      {EXT_WMASK, FEAT_WMASK, TB_WMASK, MODE_WMASK};
   localparam logic [N_SLOTS-1:0][XLEN-1:0] SLOT_FIXED =
      {{XLEN{1'b0}}, {XLEN{1'b0}}, {XLEN{1'b0}}, MODE_FIXED};

   commit_t               commit;
   logic [N_SLOTS-1:0]    slot_we;
   logic [XLEN-1:0]       slot_q [N_SLOTS];
   logic [XLEN-1:0]       mode_q, tbase_q, feat_q, ext_q, fault_q;
   logic [XLEN-1:0]       ext_view;
   logic                  long_active;
   logic                  gp_q;

   sysctl_guard u_guard (
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .new_longen (wr_data[EXT_LONGEN_B]),
      .cur_longen (ext_q[EXT_LONGEN_B]),
      .paging_on  (mode_q[MODE_PAGE_B]),
      .commit     (commit)
   );

   assign slot_we[SLOT_MODE]  = commit.mode;
   assign slot_we[SLOT_TBASE] = commit.tbase;
   assign slot_we[SLOT_FEAT]  = commit.feat;
   assign slot_we[SLOT_EXT]   = commit.ext;

   generate
      for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
         sysctl_field_reg #(
            .W     (XLEN),
            .WMASK (SLOT_WMASK[s]),
            .FIXED (SLOT_FIXED[s])
         ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (slot_we[s]),
            .d     (wr_data),
            .q     (slot_q[s])
         );
      end
   endgenerate

   assign mode_q  = slot_q[SLOT_MODE];
   assign tbase_q = slot_q[SLOT_TBASE];
   assign feat_q  = slot_q[SLOT_FEAT];
   assign ext_q   = slot_q[SLOT_EXT];

   sysctl_fault_cap #(.W(XLEN)) u_fault (
      .clk      (clk),
      .rst_n    (rst_n),
      .pf_valid (pf_valid),
      .pf_addr  (pf_addr),
      .sw_we    (commit.faddr),
      .sw_data  (wr_data),
      .q        (fault_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         gp_q <= 1'b0;
      else
         gp_q <= commit.illegal;
   end

   assign long_active = ext_q[EXT_LONGEN_B] & mode_q[MODE_PAGE_B];

   always_comb begin
      ext_view                = ext_q;
      ext_view[EXT_LONGACT_B] = long_active;
   end

   always_comb begin
      unique case (reg_sel_e'(rd_idx))
         SEL_MODE:  rd_data = mode_q;
         SEL_FADDR: rd_data = fault_q;
         SEL_TBASE: rd_data = tbase_q;
         SEL_FEAT:  rd_data = feat_q;
         SEL_EXT:   rd_data = ext_view;
         default:   rd_data = '0;
      endcase
   end

   sysctl_base_dec #(.PA_W(PA_W)) u_base (
      .word      (tbase_q[PA_W-1:3]),
      .wide_mode (feat_q[FEAT_WIDE_B]),
      .base_addr (tbase_addr_o),
      .wthru     (tbase_wthru_o),
      .nocache   (tbase_nocache_o)
   );

   assign prot_mode_o   = mode_q[MODE_PROT_B];
   assign paging_on_o   = mode_q[MODE_PAGE_B];
   assign long_active_o = long_active;
   assign gp_fault_o    = gp_q;

endmodule

// File: rtl/sysctl_regbank_chk.sv
`timescale 1ns/1ps
module sysctl_regbank_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [2:0]      rd_idx,
   input logic [XLEN-1:0] rd_data,
   input logic            pf_valid,
   input logic [XLEN-1:0] pf_addr,
   input logic            paging_on_o,
   input logic            long_active_o,
   input logic            gp_fault_o,
   input logic [XLEN-1:0] ext_q,
   input logic [XLEN-1:0] fault_q
);

   // R6
   gp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault_o |-> $stable(ext_q));

   // R6
   gp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault_o |-> $past(wr_en));

   // R6
   longen_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ext_q[8]) |-> !$past(paging_on_o));

   // R5
   lact_paging_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !paging_on_o |-> !long_active_o);

   // R8
   pf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |=> (fault_q == $past(pf_addr)));

   // R2
   fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == 3'd0) |-> rd_data[4]);

   // R7
   hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == 3'd1 || rd_idx == 3'd6 || rd_idx == 3'd7) |-> (rd_data == '0));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .rd_idx        (rd_idx),
   .rd_data       (rd_data),
   .pf_valid      (pf_valid),
   .pf_addr       (pf_addr),
   .paging_on_o   (paging_on_o),
   .long_active_o (long_active_o),
   .gp_fault_o    (gp_fault_o),
   .ext_q         (ext_q),
   .fault_q       (fault_q)
);

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_idx;
   logic [63:0] wr_data;
   logic [2:0]  rd_idx;
   logic [63:0] rd_data;
   logic        pf_valid;
   logic [63:0] pf_addr;
   logic        prot_mode_o, paging_on_o, long_active_o;
   logic [51:0] tbase_addr_o;
   logic        tbase_wthru_o, tbase_nocache_o, gp_fault_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference state
   logic [63:0] m_c0, m_c2, m_c3, m_c4, m_ef;
   logic        m_gp;

   always #5 clk = ~clk;

   sysctl_regbank u_sysctl_regbank (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_idx          (wr_idx),
      .wr_data         (wr_data),
      .rd_idx          (rd_idx),
      .rd_data         (rd_data),
      .pf_valid        (pf_valid),
      .pf_addr         (pf_addr),
      .prot_mode_o     (prot_mode_o),
      .paging_on_o     (paging_on_o),
      .long_active_o   (long_active_o),
      .tbase_addr_o    (tbase_addr_o),
      .tbase_wthru_o   (tbase_wthru_o),
      .tbase_nocache_o (tbase_nocache_o),
      .gp_fault_o      (gp_fault_o)
   );

   function automatic logic m_lact();
      return m_ef[8] & m_c0[31];
   endfunction

   function automatic logic [63:0] exp_rd(input int i);
      case (i)
         0: return m_c0;
         2: return m_c2;
         3: return m_c3;
         4: return m_c4;
         5: return m_ef | (m_lact() ? 64'h400 : 64'h0);
         default: return 64'h0;
      endcase
   endfunction

   function automatic string rd_tag(input int i);
      case (i)
         0: return "R2";
         2: return "R8";
         3: return "R9";
         4: return "R3";
         5: return "R4";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [51:0] exp_base();
      if (m_c4[5]) return {20'h0, m_c3[31:5], 5'h0};
      return {m_c3[51:12], 12'h0};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input bit in_reset);
      for (int i = 0; i < 8; i++) begin
         rd_idx = 3'(i);
         #0.5;
         chk(in_reset ? "R1" : rd_tag(i), $sformatf("read idx %0d", i),
             rd_data, exp_rd(i));
      end
      chk(in_reset ? "R1" : "R2", "prot_mode", 64'(prot_mode_o), 64'(m_c0[0]));
      chk(in_reset ? "R1" : "R2", "paging_on", 64'(paging_on_o), 64'(m_c0[31]));
      chk(in_reset ? "R1" : "R5", "long_active", 64'(long_active_o), 64'(m_lact()));
      chk(in_reset ? "R1" : "R10", "tbase_addr", 64'(tbase_addr_o), 64'(exp_base()));
      chk(in_reset ? "R1" : "R9", "wthru", 64'(tbase_wthru_o), 64'(m_c3[3]));
      chk(in_reset ? "R1" : "R9", "nocache", 64'(tbase_nocache_o), 64'(m_c3[4]));
      chk(in_reset ? "R1" : "R6", "gp_fault", 64'(gp_fault_o), 64'(m_gp));
   endtask

   task automatic cyc(input logic we, input logic [2:0] idx, input logic [63:0] d,
                      input logic pv, input logic [63:0] pa);
      logic [63:0] n0, n2, n3, n4, ne;
      logic        ng;
      wr_en = we; wr_idx = idx; wr_data = d; pf_valid = pv; pf_addr = pa;
      n0 = m_c0; n2 = m_c2; n3 = m_c3; n4 = m_c4; ne = m_ef; ng = 1'b0;
      if (we) begin
         case (idx)
            3'd0: n0 = (d & 64'hFFFF_FFEF) | 64'h10;
            3'd2: n2 = d;
            3'd3: n3 = d & 64'h000F_FFFF_FFFF_FFF8;
            3'd4: n4 = d & 64'h0000_0000_0004_07FF;
            3'd5: begin
               if (m_c0[31] && (d[8] != m_ef[8])) ng = 1'b1;
               else ne = d & 64'h7901;
            end
            default: ng = 1'b1;
         endcase
      end
      if (pv) n2 = pa;
      @(posedge clk);
      m_c0 = n0; m_c2 = n2; m_c3 = n3; m_c4 = n4; m_ef = ne; m_gp = ng;
      @(negedge clk);
      check_all(1'b0);
      wr_en = 1'b0; pf_valid = 1'b0;
   endtask

   task automatic wr(input logic [2:0] idx, input logic [63:0] d);
      cyc(1'b1, idx, d, 1'b0, 64'h0);
   endtask

   task automatic idle();
      cyc(1'b0, 3'd0, 64'h0, 1'b0, 64'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = 3'd0; wr_data = 64'h0;
      rd_idx = 3'd0; pf_valid = 1'b0; pf_addr = 64'h0;
      m_c0 = 64'h10; m_c2 = 64'h0; m_c3 = 64'h0; m_c4 = 64'h0; m_ef = 64'h0;
      m_gp = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all(1'b1);                       // R1 reset state
      rst_n = 1'b1;
      idle();                                // R1 after release

      // R2 / R11: all ones to mode word, upper half and bit 4 behaviour
      wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_idx = 3'd0; #0.5;
      chk("R11", "read after write", rd_data, 64'h0000_0000_FFFF_FFFF);
      wr(3'd0, 64'h0);
      wr(3'd0, 64'h0000_0000_0000_0001);     // protected, no paging

      // R3 feature word mask
      wr(3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd4, 64'h0000_0000_0000_0000);

      // R4 extended word mask with paging off; long enable set
      wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
      // R5 paging on after long enable -> long active
      wr(3'd0, 64'h0000_0000_8000_0001);
      // R6 clear long enable while paging -> dropped, strobe
      wr(3'd5, 64'h0);
      idle();                                // strobe gone
      // R6 write keeping long enable while paging -> accepted
      wr(3'd5, 64'h0000_0000_0000_0100);
      // R6 back-to-back illegal writes
      wr(3'd5, 64'h0);
      wr(3'd5, 64'h0);
      // R7 unimplemented indices
      wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
      idle();
      // R5 paging off drops long active, then long enable may change
      wr(3'd0, 64'h0000_0000_0000_0001);
      wr(3'd5, 64'h0);
      wr(3'd0, 64'h0000_0000_8000_0001);     // paging without long enable

      // R8 fault capture and collision
      cyc(1'b0, 3'd0, 64'h0, 1'b1, 64'hDEAD_BEEF_0123_4567);
      cyc(1'b1, 3'd2, 64'h1111_2222_3333_4444, 1'b1, 64'h8765_4321_FEDC_BA98);
      wr(3'd2, 64'hCAFE_F00D_5555_AAAA);
      cyc(1'b1, 3'd3, 64'h0, 1'b1, 64'h0000_7FFF_FFFF_F000); // pf with other write

      // R9 / R10 table base decoding
      wr(3'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd4, 64'h0000_0000_0000_0020);     // wide table mode
      wr(3'd3, 64'h0000_0ABC_1234_5678);
      wr(3'd4, 64'h0);
      wr(3'd3, 64'h0000_0ABC_1234_5010);
      wr(3'd3, 64'h0000_0000_0000_0008);     // writethrough only
      repeat (2) idle();

      finish_run();
   end

endmodule